// File: doc/BRIEF.md
# PHY Indirect Control-Register Port Responder

This block is the PHY-side end of a narrow indirect register port. A master outside the block reaches a small set of 16-bit PHY registers through one 16-bit input bus and four strobes. The strobes are capture address, capture data, commit write and read. Each strobe is answered with a four-phase acknowledge. The block latches an address and a pending write value, commits the value to the addressed register, and returns read data on a held 16-bit output bus.

Three kinds of register sit behind the port. The first is a bank of general-purpose registers with a parameterised base and count. The second is a clock/reset register at address 0x7F3F, whose bit 0 drives the PHY reset output. The third is a read-only lane status register at address 0x2003, whose bit 1 reflects the RX PLL lock input.

Setting the reset bit puts the port itself into reset. That write is never acknowledged. The reset output is held for a set number of cycles, after which the bit clears itself. The master is expected to give up waiting, drop its strobe and then poll the lock status.

Top module: `phyport_resp`

## Requirements
- R1: After synchronous reset, ack, phy_rst and rdata are 0, and the clock/reset register (address 0x7F3F) reads back as 0x0000.
- R2: Ack goes high in the cycle after a strobe is first sampled high. It stays high while any strobe is high, and goes low in the cycle after all strobes are sampled low. A strobe held high causes only one action.
- R3: The capture-address strobe loads din as the target address. The capture-data strobe loads din as the pending value. Neither of them changes any register.
- R4: The write strobe copies the pending value into the addressed general-purpose register (addresses GP_BASE to GP_BASE+NUM_GP-1). The read strobe puts the addressed register on rdata one cycle after it is sampled. rdata keeps that value until the next accepted read.
- R5: Address 0x2003 reads as 0x0002 when pll_locked is 1 and as 0x0000 when it is 0; bit 1 carries the lock state. Writes to this address are acknowledged and discarded.
- R6: Reads of an unmapped address return 0x0000. Writes to an unmapped address are acknowledged and discarded.
- R7: A write of a value with bit 0 clear to address 0x7F3F is stored in full and acknowledged, and reads back unchanged.
- R8: A write of a value with bit 0 set to address 0x7F3F gets no ack. phy_rst is high for exactly RST_CYCLES cycles, starting the cycle after the write strobe is sampled. Bit 0 then reads 0, and bits 15:1 keep the written value.
- R9: Strobes are ignored while the port is in reset. If the write strobe is still high when the reset ends, ack stays low until all strobes are released, and the held strobe starts no new action.
- R10: When several strobes rise together, only one action is taken. The order of priority is capture address, then capture data, then write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Address or data from the master |
| stb_addr | input | 1 | Capture-address strobe |
| stb_data | input | 1 | Capture-data strobe |
| stb_wr | input | 1 | Commit-write strobe |
| stb_rd | input | 1 | Read strobe |
| pll_locked | input | 1 | RX PLL lock state, synchronous to clk |
| ack | output | 1 | Handshake acknowledge |
| rdata | output | 16 | Read data, held between reads |
| phy_rst | output | 1 | PHY reset, bit 0 of the clock/reset register |

## Verification
The assertions assume the master follows the four-phase protocol. A strobe stays high until ack is seen, or until the master gives up on a reset write. No new strobe is raised until ack has fallen. They also assume pll_locked is already synchronous to clk.

The bench drives every strobe at a falling edge and holds it for two cycles. After dropping a strobe, it waits for ack to fall. Only the tests for simultaneous strobes and for the unacknowledged reset write step outside the single-strobe pattern, and those are exactly the cases that R9 and R10 define.

// File: rtl/phyport_pkg.sv
package phyport_pkg;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_ACK,
    HS_INRST,
    HS_DRAIN
  } hs_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CAP_ADDR,
    OP_CAP_DATA,
    OP_WRITE,
    OP_READ
  } port_op_e;

  localparam int          REG_W          = 16;
  localparam logic [15:0] ADDR_CLKRST    = 16'h7F3F;
  localparam logic [15:0] ADDR_LANE_STAT = 16'h2003;
  localparam int          CLKRST_RST_BIT = 0;
  localparam int          STAT_PLL_BIT   = 1;

endpackage

// File: rtl/phyport_rst_timer.sv
module phyport_rst_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CW'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/phyport_hs_fsm.sv
module phyport_hs_fsm
  import phyport_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     stb_addr,
  input  logic     stb_data,
  input  logic     stb_wr,
  input  logic     stb_rd,
  input  logic     wr_is_reset,
  input  logic     rst_done,
  output port_op_e op,
  output logic     rst_start,
  output logic     ack
);
  hs_state_e st_q, st_d;
  logic      ack_q, ack_d;
  logic      any_stb;

  assign any_stb = stb_addr | stb_data | stb_wr | stb_rd;

  always_comb begin
    st_d      = st_q;
    ack_d     = ack_q;
    op        = OP_NONE;
    rst_start = 1'b0;
    unique case (st_q)
      HS_IDLE: begin
        if (any_stb) begin
          if (stb_addr)      op = OP_CAP_ADDR;
          else if (stb_data) op = OP_CAP_DATA;
          else if (stb_wr)   op = OP_WRITE;
          else               op = OP_READ;
          if (op == OP_WRITE && wr_is_reset) begin
            st_d      = HS_INRST;
            rst_start = 1'b1;
            ack_d     = 1'b0;
          end else begin
            st_d  = HS_ACK;
            ack_d = 1'b1;
          end
        end
      end
      HS_ACK: begin
        if (!any_stb) begin
          st_d  = HS_IDLE;
          ack_d = 1'b0;
        end
      end
      HS_INRST: begin
        ack_d = 1'b0;
        if (rst_done) st_d = any_stb ? HS_DRAIN : HS_IDLE;
      end
      HS_DRAIN: begin
        ack_d = 1'b0;
        if (!any_stb) st_d = HS_IDLE;
      end
      default: begin
        st_d  = HS_IDLE;
        ack_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= HS_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  assign ack = ack_q;

endmodule

// File: rtl/phyport_regs.sv
module phyport_regs
  import phyport_pkg::*;
#(
  parameter int          NUM_GP  = 8,
  parameter logic [15:0] GP_BASE = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] din,
  input  port_op_e         op,
  input  logic             pll_locked,
  input  logic             rst_clear,
  output logic [REG_W-1:0] rdata,
  output logic             phy_rst,
  output logic             wr_is_reset
);
  localparam int IDXW = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;
  localparam logic [16:0] GP_END = {1'b0, GP_BASE} + 17'(NUM_GP);

  logic [REG_W-1:0] addr_q, data_q, clkrst_q, rdata_q;
  logic [REG_W-1:0] gp_rdata;
  logic             gp_hit;
  logic [IDXW-1:0]  gp_idx;
  logic [REG_W-1:0] rd_mux;

  assign gp_hit = ({1'b0, addr_q} >= {1'b0, GP_BASE}) && ({1'b0, addr_q} < GP_END);
  assign gp_idx = IDXW'(addr_q - GP_BASE);

  generate
    if (NUM_GP > 0) begin : g_gp_bank
      logic [REG_W-1:0] mem [NUM_GP];
      logic [REG_W-1:0] mem_rd_q;
      always_ff @(posedge clk) begin
        if (op == OP_WRITE && gp_hit) mem[gp_idx] <= data_q;
        mem_rd_q <= mem[gp_idx];
      end
      assign gp_rdata = mem_rd_q;
    end else begin : g_no_gp
      assign gp_rdata = '0;
    end
  endgenerate

  always_comb begin
    if (gp_hit && NUM_GP > 0)           rd_mux = gp_rdata;
    else if (addr_q == ADDR_CLKRST)     rd_mux = clkrst_q;
    else if (addr_q == ADDR_LANE_STAT) begin
      rd_mux               = '0;
      rd_mux[STAT_PLL_BIT] = pll_locked;
    end else                            rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      data_q   <= '0;
      clkrst_q <= '0;
      rdata_q  <= '0;
    end else begin
      unique case (op)
        OP_CAP_ADDR: addr_q <= din;
        OP_CAP_DATA: data_q <= din;
        OP_WRITE:    if (addr_q == ADDR_CLKRST) clkrst_q <= data_q;
        OP_READ:     rdata_q <= rd_mux;
        default: ;
      endcase
      if (rst_clear) clkrst_q[CLKRST_RST_BIT] <= 1'b0;
    end
  end

  assign wr_is_reset = (addr_q == ADDR_CLKRST) && data_q[CLKRST_RST_BIT];
  assign phy_rst     = clkrst_q[CLKRST_RST_BIT];
  assign rdata       = rdata_q;

endmodule

// File: rtl/phyport_resp.sv
module phyport_resp
  import phyport_pkg::*;
#(
  parameter int          NUM_GP     = 8,
  parameter logic [15:0] GP_BASE    = 16'h0000,
  parameter int          RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] din,
  input  logic        stb_addr,
  input  logic        stb_data,
  input  logic        stb_wr,
  input  logic        stb_rd,
  input  logic        pll_locked,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        phy_rst
);
  port_op_e op;
  logic     rst_start, rst_done, wr_is_reset;

  phyport_hs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stb_addr   (stb_addr),
    .stb_data   (stb_data),
    .stb_wr     (stb_wr),
    .stb_rd     (stb_rd),
    .wr_is_reset(wr_is_reset),
    .rst_done   (rst_done),
    .op         (op),
    .rst_start  (rst_start),
    .ack        (ack)
  );

  phyport_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(rst_start),
    .done (rst_done)
  );

  phyport_regs #(.NUM_GP(NUM_GP), .GP_BASE(GP_BASE)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .op         (op),
    .pll_locked (pll_locked),
    .rst_clear  (rst_done),
    .rdata      (rdata),
    .phy_rst    (phy_rst),
    .wr_is_reset(wr_is_reset)
  );

endmodule

// File: rtl/phyport_resp_chk.sv
module phyport_resp_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        stb_addr,
  input logic        stb_data,
  input logic        stb_wr,
  input logic        stb_rd,
  input logic        ack,
  input logic [15:0] rdata,
  input logic        phy_rst
);
  logic any_stb;
  int   hi_cnt;

  assign any_stb = stb_addr | stb_data | stb_wr | stb_rd;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= 0;
    else if (phy_rst) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(any_stb));

  // R2
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !any_stb) |=> !ack);

  // R8
  rst_noack_chk: assert property (@(posedge clk) disable iff (rst)
    phy_rst |-> !ack);

  // R8
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst) |-> (hi_cnt == RST_CYCLES));

  // R8
  rst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= RST_CYCLES);

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_rd |=> $stable(rdata));

endmodule

bind phyport_resp phyport_resp_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .stb_addr(stb_addr),
  .stb_data(stb_data),
  .stb_wr  (stb_wr),
  .stb_rd  (stb_rd),
  .ack     (ack),
  .rdata   (rdata),
  .phy_rst (phy_rst)
);

// File: tb/phyport_resp_tb_top.sv
module phyport_resp_tb_top;
  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic        stb_addr = 0, stb_data = 0, stb_wr = 0, stb_rd = 0;
  logic        pll_locked = 1'b1;
  logic        ack, phy_rst;
  logic [15:0] rdata;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  phyport_resp #(.NUM_GP(8), .GP_BASE(16'h0000), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst(rst), .din(din),
    .stb_addr(stb_addr), .stb_data(stb_data), .stb_wr(stb_wr), .stb_rd(stb_rd),
    .pll_locked(pll_locked), .ack(ack), .rdata(rdata), .phy_rst(phy_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // mask bits: 0 capture address, 1 capture data, 2 write, 3 read
  task automatic hs(input logic [3:0] mask, input logic [15:0] d, input string req);
    @(negedge clk);
    din = d;
    {stb_rd, stb_wr, stb_data, stb_addr} = mask;
    @(negedge clk);
    chk(ack === 1'b1, {req, "/R2 ack rise"}, 16'(ack), 16'h1);
    @(negedge clk);
    chk(ack === 1'b1, {req, "/R2 ack held"}, 16'(ack), 16'h1);
    {stb_rd, stb_wr, stb_data, stb_addr} = 4'b0;
    @(negedge clk);
    chk(ack === 1'b0, {req, "/R2 ack fall"}, 16'(ack), 16'h0);
  endtask

  task automatic rd_exp(input logic [15:0] exp, input string req);
    hs(4'b1000, 16'h0, req);
    chk(rdata === exp, req, rdata, exp);
  endtask

  // {op[1:0], arg[15:0], exp[15:0]}; op 0 capaddr, 1 capdata, 2 write, 3 read
  localparam int NV = 22;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'h0002, 16'h0}, {2'd1, 16'hBEEF, 16'h0}, {2'd2, 16'h0, 16'h0}, {2'd3, 16'h0, 16'hBEEF},
    {2'd0, 16'h0005, 16'h0}, {2'd1, 16'h1234, 16'h0}, {2'd2, 16'h0, 16'h0}, {2'd3, 16'h0, 16'h1234},
    {2'd0, 16'h0002, 16'h0}, {2'd3, 16'h0, 16'hBEEF},
    {2'd0, 16'h7F3F, 16'h0}, {2'd1, 16'h5A50, 16'h0}, {2'd2, 16'h0, 16'h0}, {2'd3, 16'h0, 16'h5A50},
    {2'd0, 16'h2003, 16'h0}, {2'd3, 16'h0, 16'h0002}, {2'd1, 16'hFFFF, 16'h0}, {2'd2, 16'h0, 16'h0},
    {2'd3, 16'h0, 16'h0002},
    {2'd0, 16'h1234, 16'h0}, {2'd2, 16'h0, 16'h0}, {2'd3, 16'h0, 16'h0000}
  };

  initial begin
    int hi;
    bit ack_seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ack === 1'b0, "R1 ack", 16'(ack), 16'h0);
    chk(phy_rst === 1'b0, "R1 phy_rst", 16'(phy_rst), 16'h0);
    chk(rdata === 16'h0, "R1 rdata", rdata, 16'h0);
    hs(4'b0001, 16'h7F3F, "R1");
    rd_exp(16'h0000, "R1 clkrst");

    // table: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][33:32])
        2'd0: hs(4'b0001, VEC[i][31:16], "R3 vec");
        2'd1: hs(4'b0010, VEC[i][31:16], "R3 vec");
        2'd2: hs(4'b0100, 16'h0, "R6 vec");
        default: rd_exp(VEC[i][15:0], "R4/R5/R6/R7 vec");
      endcase
    end

    // R3: capture without write does not commit
    hs(4'b0001, 16'h0005, "R3");
    hs(4'b0010, 16'h9999, "R3");
    rd_exp(16'h1234, "R3 no commit");
    hs(4'b0100, 16'h0, "R3");
    rd_exp(16'h9999, "R3 pending kept");

    // R10 priority
    hs(4'b1001, 16'h0002, "R10");
    chk(rdata === 16'h9999, "R10 addr beats read", rdata, 16'h9999);
    rd_exp(16'hBEEF, "R10 addr taken");
    hs(4'b0110, 16'h1111, "R10");
    rd_exp(16'hBEEF, "R10 data beats write");
    hs(4'b0100, 16'h0, "R10");
    rd_exp(16'h1111, "R10 data taken");

    // R5 lock low
    pll_locked = 1'b0;
    hs(4'b0001, 16'h2003, "R5");
    rd_exp(16'h0000, "R5 unlocked");

    // R8 / R9 self-resetting write
    hs(4'b0001, 16'h7F3F, "R8");
    hs(4'b0010, 16'h5A51, "R8");
    @(negedge clk);
    stb_wr = 1'b1;
    hi = 0;
    ack_seen = 0;
    for (int k = 0; k < RSTC + 4; k++) begin
      @(negedge clk);
      if (phy_rst) hi++;
      if (ack) ack_seen = 1;
    end
    chk(hi == RSTC, "R8 reset length", 16'(hi), 16'(RSTC));
    chk(!ack_seen, "R8 no ack", 16'(ack_seen), 16'h0);
    chk(ack === 1'b0 && phy_rst === 1'b0, "R9 held strobe", 16'({ack, phy_rst}), 16'h0);
    stb_wr = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R9 after release", 16'(ack), 16'h0);
    rd_exp(16'h5A50, "R8 bit cleared");
    chk(phy_rst === 1'b0, "R8 phy_rst low", 16'(phy_rst), 16'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule